// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Logic

This block sits beside a two-port shared memory. It watches the accesses that each port makes and drives one interrupt line toward each port, so that the ports can send messages to each other. The two highest addresses of the memory serve as mailboxes. The left port owns the address one below the top, and the right port owns the top address. When one port writes into the other port's mailbox, the owner's interrupt is raised. The owner clears it by reading its own mailbox.

The busy flags come from the contention arbiter, which is outside this block. A port that is flagged busy can neither raise the interrupt toward its peer nor clear its own interrupt. The memory array and the arbiter are not part of this block. Every access is sampled on the rising clock edge, and the interrupt outputs are registered, so the result of an access appears one cycle later.

Top module: `mbx_irq_top`

## Requirements
- R1: After a synchronous reset (rst_n low at a rising edge), both `l_irq_n` and `r_irq_n` are high (inactive).
- R2: A left write (l_en=1, l_we=1) to the top address (all address bits 1) with l_busy=0 drives `r_irq_n` low at the next rising edge.
- R3: A right write (r_en=1, r_we=1) to the top address minus one (all address bits 1 except bit 0, which is 0) with r_busy=0 drives `l_irq_n` low at the next rising edge.
- R4: An owner read (en=1, we=0) of its own mailbox with its busy low sets that port's interrupt output high at the next edge. For the right port this is a read of the top address; for the left port it is a read of the top address minus one.
- R5: A port that reads the other port's mailbox changes neither interrupt output.
- R6: A mailbox write made while the writer's busy is high does not assert the peer's interrupt.
- R7: An owner read made while the owner's busy is high does not clear its interrupt.
- R8: If a set and a clear of the same interrupt occur in the same cycle, the interrupt ends up asserted (low).
- R9: An idle cycle, an access to a non-mailbox address, or a write by a port to its own mailbox leaves both interrupt outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| l_en | input | 1 | Left port access enable |
| l_we | input | 1 | Left port write strobe (1 = write, 0 = read) |
| l_addr | input | ADDR_W | Left port address |
| l_busy | input | 1 | Left port lost contention (from arbiter) |
| r_en | input | 1 | Right port access enable |
| r_we | input | 1 | Right port write strobe (1 = write, 0 = read) |
| r_addr | input | ADDR_W | Right port address |
| r_busy | input | 1 | Right port lost contention (from arbiter) |
| l_irq_n | output | 1 | Interrupt to the left port, active low |
| r_irq_n | output | 1 | Interrupt to the right port, active low |

## Verification
The assertions check three things on every cycle:
- each flag register obeys set priority, clear and hold;
- both outputs stay frozen while both ports are busy;
- both outputs stay frozen in a cycle with no access.

The address-dependent behaviours can only be shown by the bench's scenarios:
- the mailbox address decode;
- a read of the peer's mailbox having no effect;
- a write to a port's own mailbox having no effect;
- the gating by busy of exactly one side of a transaction.

These scenarios are checked against a cycle model kept in the bench.

// File: rtl/mbx_pkg.sv
// Package mbx_pkg
// Shared types for the mailbox interrupt logic.
// Assumes: nothing beyond IEEE 1800-2017.
package mbx_pkg;
    // Requests one port's access can raise toward the interrupt flags.
    typedef struct packed {
        logic post_peer;  // valid write into the other port's mailbox
        logic fetch_own;  // valid read of this port's own mailbox
    } mbx_req_t;

    // Which of the two top addresses a port owns.
    localparam bit SLOT_BELOW_TOP = 1'b0;
    localparam bit SLOT_TOP       = 1'b1;
endpackage

// File: rtl/mbx_port_decode.sv
// Module mbx_port_decode
// Turns one port's access (enable, write strobe, address, busy) into
// mailbox requests. OWN_SLOT gives the low address bit of the mailbox
// owned by this port; the peer's mailbox uses the other value of that bit.
// Assumes: busy is already resolved by the arbiter for this cycle.
module mbx_port_decode
    import mbx_pkg::*;
#(
    parameter int ADDR_W   = 15,
    parameter bit OWN_SLOT = SLOT_TOP
) (
    input  logic              en_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              busy_i,
    output mbx_req_t          req_o
);
    localparam logic [ADDR_W-1:0] OWN_ADDR  = {{(ADDR_W-1){1'b1}}, OWN_SLOT};
    localparam logic [ADDR_W-1:0] PEER_ADDR = {{(ADDR_W-1){1'b1}}, ~OWN_SLOT};

    logic live;

    // A port takes part in mailbox signalling only when enabled and not busy.
    always_comb begin
        live              = en_i && !busy_i;
        req_o.post_peer   = live && we_i  && (addr_i == PEER_ADDR);
        req_o.fetch_own   = live && !we_i && (addr_i == OWN_ADDR);
    end
endmodule

// File: rtl/mbx_irq_flag.sv
// Module mbx_irq_flag
// One pending-message flag with an active-low interrupt output.
// Set wins over clear in the same cycle.
// Assumes: synchronous active-low reset held for at least one edge.
module mbx_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic irq_n
);
    logic pending;

    // Update the pending flag: reset empties it, set wins, clear empties it.
    always_ff @(posedge clk) begin
        if (!rst_n)     pending <= 1'b0;
        else if (set_i) pending <= 1'b1;
        else if (clr_i) pending <= 1'b0;
    end

    // The output is the inverted flag.
    always_comb irq_n = !pending;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> !irq_n);                                        // R8
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> irq_n);                             // R4
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !set_i) |=> $stable(irq_n));                   // R9
endmodule

// File: rtl/mbx_irq_top.sv
// Module mbx_irq_top
// Interrupt logic for port-to-port messaging across a shared two-port
// memory. The top address is the right port's mailbox and the address one
// below it is the left port's mailbox. A write into the peer's mailbox
// raises the peer's interrupt. An owner read of its own mailbox clears it.
// Busy gates both actions.
// Assumes: accesses are single-cycle and sampled on the rising edge.
module mbx_irq_top
    import mbx_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_en,
    input  logic              l_we,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              l_busy,
    input  logic              r_en,
    input  logic              r_we,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic              r_busy,
    output logic              l_irq_n,
    output logic              r_irq_n
);
    localparam int NPORT = 2;  // index 0 = left, 1 = right

    logic [NPORT-1:0]              en_v, we_v, busy_v, irq_v;
    logic [NPORT-1:0][ADDR_W-1:0]  addr_v;
    mbx_req_t [NPORT-1:0]          req_v;

    // Gather both ports into indexed vectors.
    always_comb begin
        en_v   = {r_en,   l_en};
        we_v   = {r_we,   l_we};
        busy_v = {r_busy, l_busy};
        addr_v = {r_addr, l_addr};
    end

    for (genvar g = 0; g < NPORT; g++) begin : g_port
        // Left owns the slot below the top; right owns the top slot.
        mbx_port_decode #(
            .ADDR_W   (ADDR_W),
            .OWN_SLOT ((g == 0) ? SLOT_BELOW_TOP : SLOT_TOP)
        ) i_dec (
            .en_i   (en_v[g]),
            .we_i   (we_v[g]),
            .addr_i (addr_v[g]),
            .busy_i (busy_v[g]),
            .req_o  (req_v[g])
        );

        // The peer posts into this port's flag; this port drains it.
        mbx_irq_flag i_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (req_v[NPORT-1-g].post_peer),
            .clr_i (req_v[g].fetch_own),
            .irq_n (irq_v[g])
        );
    end

    // Drive the named outputs.
    always_comb begin
        l_irq_n = irq_v[0];
        r_irq_n = irq_v[1];
    end

    AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (l_busy && r_busy) |=> $stable({l_irq_n, r_irq_n}));        // R7
    AST_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_en && !r_en) |=> $stable({l_irq_n, r_irq_n}));          // R9
endmodule

// File: tb/test_mbx_irq_top.sv
module test_mbx_irq_top;
    localparam int AW = 15;
    localparam logic [AW-1:0] TOP   = {AW{1'b1}};
    localparam logic [AW-1:0] BELOW = {{(AW-1){1'b1}}, 1'b0};

    logic clk = 1'b0;
    logic rst_n;
    logic l_en, l_we, l_busy, r_en, r_we, r_busy;
    logic [AW-1:0] l_addr, r_addr;
    logic l_irq_n, r_irq_n;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    bit exp_l  = 1'b0;  // model: left pending
    bit exp_r  = 1'b0;  // model: right pending

    always #2 clk = ~clk;  // 250 MHz

    mbx_irq_top #(.ADDR_W(AW)) i_mbx_irq_top (
        .clk, .rst_n, .l_en, .l_we, .l_addr, .l_busy,
        .r_en, .r_we, .r_addr, .r_busy, .l_irq_n, .r_irq_n
    );

    task automatic check(input bit ok, input string tag, input logic act, input logic exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    // Name the rule that governs the right interrupt this cycle.
    function automatic string tag_r(bit post, bit clr);
        if (post && clr) return "R8";
        if (post) return "R2";
        if (clr) return "R4";
        if (l_en && l_we && l_addr == TOP && l_busy) return "R6";
        if (r_en && !r_we && r_addr == TOP && r_busy) return "R7";
        if (l_en && !l_we && l_addr == TOP) return "R5";
        return "R9";
    endfunction

    // Name the rule that governs the left interrupt this cycle.
    function automatic string tag_l(bit post, bit clr);
        if (post && clr) return "R8";
        if (post) return "R3";
        if (clr) return "R4";
        if (r_en && r_we && r_addr == BELOW && r_busy) return "R6";
        if (l_en && !l_we && l_addr == BELOW && l_busy) return "R7";
        if (r_en && !r_we && r_addr == BELOW) return "R5";
        return "R9";
    endfunction

    // Drive one cycle, advance the model, and compare after the edge.
    task automatic step(input bit le, lw, input logic [AW-1:0] la, input bit lb,
                        input bit re, rw, input logic [AW-1:0] ra, input bit rb);
        bit post_r, clr_r, post_l, clr_l;
        string tr, tl;
        l_en = le; l_we = lw; l_addr = la; l_busy = lb;
        r_en = re; r_we = rw; r_addr = ra; r_busy = rb;
        post_r = le && lw && la == TOP && !lb;
        clr_r  = re && !rw && ra == TOP && !rb;
        post_l = re && rw && ra == BELOW && !rb;
        clr_l  = le && !lw && la == BELOW && !lb;
        tr = tag_r(post_r, clr_r);
        tl = tag_l(post_l, clr_l);
        exp_r = post_r ? 1'b1 : (clr_r ? 1'b0 : exp_r);
        exp_l = post_l ? 1'b1 : (clr_l ? 1'b0 : exp_l);
        @(negedge clk);
        check(r_irq_n == !exp_r, tr, r_irq_n, !exp_r);
        check(l_irq_n == !exp_l, tl, l_irq_n, !exp_l);
    endtask

    function automatic logic [AW-1:0] pick_addr();
        if ($urandom % 4 == 0) return AW'($urandom);
        return ($urandom % 2) ? TOP : BELOW;
    endfunction

    initial begin
        #800000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 1'b0;
        {l_en, l_we, l_busy, r_en, r_we, r_busy} = '0;
        l_addr = '0;
        r_addr = '0;
        repeat (3) @(negedge clk);
        check(l_irq_n == 1'b1, "R1", l_irq_n, 1'b1);
        check(r_irq_n == 1'b1, "R1", r_irq_n, 1'b1);
        rst_n = 1'b1;

        // Directed corner cases.
        step(1,1,TOP,1,   0,0,0,0);      // R6: busy writer blocked
        step(1,1,TOP,0,   0,0,0,0);      // R2: right interrupt set
        step(1,0,TOP,0,   0,0,0,0);      // R5: left reads peer box
        step(0,0,0,0,     1,1,TOP,0);    // R9: right writes own box
        step(0,0,0,0,     1,0,TOP,1);    // R7: busy owner cannot clear
        step(0,0,0,0,     1,0,TOP,0);    // R4: owner read clears
        step(0,0,0,0,     1,1,BELOW,0);  // R3: left interrupt set
        step(0,0,0,0,     1,0,BELOW,0);  // R5: right reads peer box
        step(1,0,BELOW,0, 1,1,BELOW,0);  // R8: set wins over clear
        step(1,0,BELOW,0, 0,0,0,0);      // R4: left clears
        step(1,1,TOP,0,   1,0,TOP,0);    // R8: right side same cycle
        step(1,1,AW'(5),0, 1,1,AW'(7),0); // R9: ordinary addresses

        // Random traffic biased toward the mailboxes.
        for (int i = 0; i < 4000; i++) begin
            step($urandom % 4 != 0, $urandom % 2, pick_addr(), $urandom % 4 == 0,
                 $urandom % 4 != 0, $urandom % 2, pick_addr(), $urandom % 4 == 0);
        end

        // Reset in the middle of traffic returns both interrupts to inactive.
        rst_n = 1'b0;
        @(negedge clk);
        exp_l = 1'b0;
        exp_r = 1'b0;
        check(l_irq_n == 1'b1, "R1", l_irq_n, 1'b1);
        check(r_irq_n == 1'b1, "R1", r_irq_n, 1'b1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule